// File: doc/BRIEF.md
# Vectored Interrupt Event Controller

This block collects single-cycle event pulses from five sources: two divider overflows, two timer underflows and one external port change. Each pulse is latched in its own flag bit of an 8-bit event image. A request is raised toward the core only when three conditions hold together: a flag is pending, the matching per-source enable bit is set, and the global enable is set. With the request, the block presents a fixed vector address for the highest-priority pending source.

Software controls the block through command strobes. One strobe enables interrupts. One disables them. One writes the per-source enable register, which also re-arms the global enable. One clears flags through a mask. When the core acknowledges a request, the global enable drops at once, which inhibits further requests until software re-arms it. The flag itself stays pending until software clears it.

The block also tracks a low-power hold state. An interrupt that arrives while the core is held releases the hold for the service routine. When the core signals its return, the block puts the core back into hold.

Top module: `irq_event_ctrl`

## Requirements
- R1: Synchronous reset clears all event flags, the per-source enables, the global enable and the hold state, so `irq_req_o` and `hold_o` read 0 after reset.
- R2: `irq_req_o` is 1 only when some flag is pending, its enable bit is set and the global enable is set. The edge that samples an event pulse, enable write or enable command also updates `irq_req_o` and `irq_vec_o`.
- R3: An acknowledge while `irq_req_o` is 1 clears the global enable at that edge. `irq_req_o` drops and `irq_vec_o` keeps its value. The flag stays set, so re-enabling raises the request again with no new event. An acknowledge while no request is pending changes nothing.
- R4: `cmd_dis_i` clears the global enable. When it arrives together with an enable command, the disable wins.
- R5: `cmd_en_i` sets the global enable. `ien_wr_i` loads the per-source enables from `ien_data_i` and also sets the global enable. Data bits 3, 5 and 6 have no effect.
- R6: `flag_clr_i` clears every flag whose bit is 1 in `flag_mask_i`. An event pulse in the same cycle as the clear of the same bit leaves that flag set.
- R7: The event inputs map to flag and enable bit positions as follows: `evt_i[0]` (divider 0) to bit 0, `evt_i[1]` (timer 0) to bit 1, `evt_i[2]` (port change) to bit 2, `evt_i[3]` (timer 1) to bit 4, and `evt_i[4]` (divider 1) to bit 7.
- R8: The vectors are 0x04 for divider 0, 0x08 for timer 0, 0x0C for port, 0x14 for timer 1 and 0x20 for divider 1. When several sources are pending and enabled, the one with the smallest vector wins.
- R9: `hold_req_i` sets `hold_o` at the next edge.
- R10: While `hold_o` is 1, a pending request clears `hold_o` one edge after `irq_req_o` rises.
- R11: `irq_ret_i` after a hold wake-up sets `hold_o` again at the next edge. `irq_ret_i` with no prior wake-up leaves `hold_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | 5 | Event pulses: div0, tmr0, port, tmr1, div1 |
| cmd_en_i | input | 1 | Enable-interrupts command strobe |
| cmd_dis_i | input | 1 | Disable-interrupts command strobe |
| ien_wr_i | input | 1 | Per-source enable write strobe |
| ien_data_i | input | 8 | Per-source enable data (bits 0,1,2,4,7) |
| flag_clr_i | input | 1 | Flag clear strobe |
| flag_mask_i | input | 8 | Flags to clear (bits 0,1,2,4,7) |
| hold_req_i | input | 1 | Request to enter hold |
| irq_ack_i | input | 1 | Core accepts the interrupt |
| irq_ret_i | input | 1 | Core returns from the service routine |
| irq_req_o | output | 1 | Interrupt request |
| irq_vec_o | output | 8 | Vector address |
| hold_o | output | 1 | Hold state |

## Verification
The request and the vector are registered from next-state values, so they are due at the same edge that samples an event, a command or an acknowledge. The bench drives every stimulus after a falling edge and reads the outputs at the following falling edge. Hold release takes one edge more, because it reacts to the registered request, so the bench reads `hold_o` at two falling edges: at the first it expects hold still set, and at the second it expects hold released. A return re-enters hold at the first edge. The exhaustive sweep covers all 32 event patterns against all 32 enable patterns and predicts each request and vector arithmetically.

// File: rtl/irq_evt_pkg.sv
package irq_evt_pkg;
  localparam int NSRC  = 5;
  localparam int REG_W = 8;
  localparam int VEC_W = 8;

  // register bit position of each source (index 0 = highest priority)
  function automatic int src_bit(input int s);
    case (s)
      0: return 0;
      1: return 1;
      2: return 2;
      3: return 4;
      default: return 7;
    endcase
  endfunction

  function automatic logic [VEC_W-1:0] src_vec(input int s);
    case (s)
      0: return VEC_W'(8'h04);
      1: return VEC_W'(8'h08);
      2: return VEC_W'(8'h0C);
      3: return VEC_W'(8'h14);
      default: return VEC_W'(8'h20);
    endcase
  endfunction

  function automatic logic [REG_W-1:0] impl_mask();
    logic [REG_W-1:0] m;
    m = '0;
    for (int s = 0; s < NSRC; s++) m[src_bit(s)] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank
  import irq_evt_pkg::*;
#(
  parameter int N = NSRC,
  parameter int W = REG_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] evt_i,
  input  logic         clr_i,
  input  logic [W-1:0] clr_mask_i,
  output logic [N-1:0] flag_nx_o,
  output logic [N-1:0] flag_q_o
);
  logic unused_mask_par;
  assign unused_mask_par = ^clr_mask_i;

  for (genvar g = 0; g < N; g++) begin : g_flag
    // set has priority over a same-cycle clear
    assign flag_nx_o[g] = evt_i[g] | (flag_q_o[g] & ~(clr_i & clr_mask_i[src_bit(g)]));

    always_ff @(posedge clk) begin
      if (rst) flag_q_o[g] <= 1'b0;
      else     flag_q_o[g] <= flag_nx_o[g];
    end

    assert_set_wins_R6: assert property (@(posedge clk) disable iff (rst)
      evt_i[g] |=> flag_q_o[g]);
    assert_clear_R6: assert property (@(posedge clk) disable iff (rst)
      (clr_i && clr_mask_i[src_bit(g)] && !evt_i[g]) |=> !flag_q_o[g]);
  end
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc
  import irq_evt_pkg::*;
#(
  parameter int N  = NSRC,
  parameter int VW = VEC_W
) (
  input  logic [N-1:0]  pend_i,
  output logic          any_o,
  output logic [VW-1:0] vec_o
);
  always_comb begin
    any_o = |pend_i;
    vec_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (pend_i[i]) vec_o = VW'(src_vec(i));
    end
  end
endmodule

// File: rtl/irq_hold_seq.sv
module irq_hold_seq (
  input  logic clk,
  input  logic rst,
  input  logic hold_req_i,
  input  logic req_i,
  input  logic ret_i,
  output logic hold_o
);
  logic from_hold_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_o      <= 1'b0;
      from_hold_q <= 1'b0;
    end else if (hold_o && req_i) begin
      hold_o      <= 1'b0;
      from_hold_q <= 1'b1;
    end else if (ret_i && from_hold_q) begin
      hold_o      <= 1'b1;
      from_hold_q <= 1'b0;
    end else if (hold_req_i) begin
      hold_o <= 1'b1;
    end
  end

  assert_wake_R10: assert property (@(posedge clk) disable iff (rst)
    (hold_o && req_i) |=> !hold_o);
  assert_resleep_R11: assert property (@(posedge clk) disable iff (rst)
    (ret_i && from_hold_q) |=> hold_o);
  assert_ret_idle_R11: assert property (@(posedge clk) disable iff (rst)
    (ret_i && !from_hold_q && !hold_o && !hold_req_i) |=> !hold_o);
  assert_enter_R9: assert property (@(posedge clk) disable iff (rst)
    (hold_req_i && !(hold_o && req_i) && !from_hold_q) |=> hold_o);
endmodule

// File: rtl/irq_event_ctrl.sv
module irq_event_ctrl
  import irq_evt_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [NSRC-1:0]  evt_i,
  input  logic             cmd_en_i,
  input  logic             cmd_dis_i,
  input  logic             ien_wr_i,
  input  logic [REG_W-1:0] ien_data_i,
  input  logic             flag_clr_i,
  input  logic [REG_W-1:0] flag_mask_i,
  input  logic             hold_req_i,
  input  logic             irq_ack_i,
  input  logic             irq_ret_i,
  output logic             irq_req_o,
  output logic [VEC_W-1:0] irq_vec_o,
  output logic             hold_o
);
  logic [NSRC-1:0]  flag_nx, flag_q;
  logic [NSRC-1:0]  ien_nx, ien_q;
  logic [NSRC-1:0]  pend_nx;
  logic             gie_nx, gie_q;
  logic             take;
  logic             any_nx;
  logic [VEC_W-1:0] vec_nx;
  logic             unused_ien_par;

  assign unused_ien_par = ^{ien_data_i, flag_q};

  irq_flag_bank #(.N(NSRC), .W(REG_W)) u_flags (
    .clk(clk), .rst(rst), .evt_i(evt_i),
    .clr_i(flag_clr_i), .clr_mask_i(flag_mask_i),
    .flag_nx_o(flag_nx), .flag_q_o(flag_q)
  );

  for (genvar g = 0; g < NSRC; g++) begin : g_ien
    assign ien_nx[g] = ien_wr_i ? ien_data_i[src_bit(g)] : ien_q[g];
  end

  assign take = irq_ack_i & irq_req_o;

  always_comb begin
    gie_nx = gie_q;
    if (cmd_en_i || ien_wr_i) gie_nx = 1'b1;
    if (cmd_dis_i)            gie_nx = 1'b0;
    if (take)                 gie_nx = 1'b0;
  end

  assign pend_nx = flag_nx & ien_nx & {NSRC{gie_nx}};

  irq_prio_enc #(.N(NSRC), .VW(VEC_W)) u_enc (
    .pend_i(pend_nx), .any_o(any_nx), .vec_o(vec_nx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ien_q     <= '0;
      gie_q     <= 1'b0;
      irq_req_o <= 1'b0;
      irq_vec_o <= '0;
    end else begin
      ien_q     <= ien_nx;
      gie_q     <= gie_nx;
      irq_req_o <= any_nx;
      if (any_nx) irq_vec_o <= vec_nx;
    end
  end

  irq_hold_seq u_hold (
    .clk(clk), .rst(rst), .hold_req_i(hold_req_i),
    .req_i(irq_req_o), .ret_i(irq_ret_i), .hold_o(hold_o)
  );

  assert_req_gated_R2: assert property (@(posedge clk) disable iff (rst)
    irq_req_o |-> (gie_q && (|(flag_q & ien_q))));
  assert_ack_inhibit_R3: assert property (@(posedge clk) disable iff (rst)
    (irq_ack_i && irq_req_o) |=> (!gie_q && !irq_req_o && $stable(irq_vec_o)));
  assert_disable_R4: assert property (@(posedge clk) disable iff (rst)
    cmd_dis_i |=> !gie_q);
  assert_enable_R5: assert property (@(posedge clk) disable iff (rst)
    ((cmd_en_i || ien_wr_i) && !cmd_dis_i && !(irq_ack_i && irq_req_o)) |=> gie_q);
  assert_vec_legal_R8: assert property (@(posedge clk) disable iff (rst)
    irq_req_o |-> (irq_vec_o == 8'h04 || irq_vec_o == 8'h08 || irq_vec_o == 8'h0C ||
                   irq_vec_o == 8'h14 || irq_vec_o == 8'h20));
endmodule

// File: tb/test_irq_event_ctrl.sv
module test_irq_event_ctrl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [4:0] evt_i = '0;
  logic       cmd_en_i = 1'b0, cmd_dis_i = 1'b0, ien_wr_i = 1'b0, flag_clr_i = 1'b0;
  logic [7:0] ien_data_i = '0, flag_mask_i = '0;
  logic       hold_req_i = 1'b0, irq_ack_i = 1'b0, irq_ret_i = 1'b0;
  logic       irq_req_o, hold_o;
  logic [7:0] irq_vec_o;
  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  irq_event_ctrl i_irq_event_ctrl (
    .clk(clk), .rst(rst), .evt_i(evt_i), .cmd_en_i(cmd_en_i), .cmd_dis_i(cmd_dis_i),
    .ien_wr_i(ien_wr_i), .ien_data_i(ien_data_i), .flag_clr_i(flag_clr_i),
    .flag_mask_i(flag_mask_i), .hold_req_i(hold_req_i), .irq_ack_i(irq_ack_i),
    .irq_ret_i(irq_ret_i), .irq_req_o(irq_req_o), .irq_vec_o(irq_vec_o), .hold_o(hold_o)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  function automatic logic [7:0] expand(input logic [4:0] s);
    logic [7:0] r;
    r = {s[4], 2'b00, s[3], 1'b0, s[2], s[1], s[0]};
    return r;
  endfunction

  function automatic logic [7:0] exp_vec(input logic [4:0] p);
    if (p[0]) return 8'h04;
    if (p[1]) return 8'h08;
    if (p[2]) return 8'h0C;
    if (p[3]) return 8'h14;
    return 8'h20;
  endfunction

  task automatic do_reset();
    rst = 1'b1; tick(); rst = 1'b0;
  endtask

  task automatic wr_ien(input logic [7:0] d);
    ien_wr_i = 1'b1; ien_data_i = d; tick(); ien_wr_i = 1'b0; ien_data_i = '0;
  endtask

  task automatic pulse(input logic [4:0] e);
    evt_i = e; tick(); evt_i = '0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: run did not finish actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    tick(); tick(); rst = 1'b0; tick();
    chk("R1 req after reset", irq_req_o, 0);
    chk("R1 hold after reset", hold_o, 0);

    // exhaustive sweep: enables x events (R2, R7, R8)
    for (int en = 0; en < 32; en++) begin
      for (int ev = 0; ev < 32; ev++) begin
        do_reset();
        wr_ien(expand(5'(en)));
        pulse(5'(ev));
        chk("R2 sweep req", irq_req_o, (5'(en) & 5'(ev)) != 0);
        if ((5'(en) & 5'(ev)) != 0)
          chk("R8 R7 sweep vec", irq_vec_o, exp_vec(5'(en) & 5'(ev)));
      end
    end

    // R4 / R5 global enable
    do_reset();
    wr_ien(8'h97);
    pulse(5'h1F);
    chk("R2 all pending", irq_req_o, 1);
    cmd_dis_i = 1'b1; tick(); cmd_dis_i = 1'b0;
    chk("R4 disable drops req", irq_req_o, 0);
    cmd_en_i = 1'b1; cmd_dis_i = 1'b1; tick(); cmd_en_i = 1'b0; cmd_dis_i = 1'b0;
    chk("R4 disable wins", irq_req_o, 0);
    cmd_en_i = 1'b1; tick(); cmd_en_i = 1'b0;
    chk("R5 enable restores req", irq_req_o, 1);
    chk("R8 top priority vec", irq_vec_o, 8'h04);

    // R6 clear and set-wins
    flag_clr_i = 1'b1; flag_mask_i = 8'h01; tick(); flag_clr_i = 1'b0;
    chk("R6 clear div0", irq_vec_o, 8'h08);
    flag_clr_i = 1'b1; flag_mask_i = 8'h02; evt_i = 5'h02; tick();
    flag_clr_i = 1'b0; evt_i = '0;
    chk("R6 set wins over clear", irq_vec_o, 8'h08);
    flag_clr_i = 1'b1; flag_mask_i = 8'hFF; tick(); flag_clr_i = 1'b0; flag_mask_i = '0;
    chk("R6 clear all", irq_req_o, 0);

    // R5 unused enable bits
    do_reset();
    pulse(5'h1F);
    wr_ien(8'h68);
    chk("R5 unused bits no effect", irq_req_o, 0);
    wr_ien(8'h80);
    chk("R5 enable write arms", irq_req_o, 1);
    chk("R7 div1 vec", irq_vec_o, 8'h20);

    // R3 acknowledge
    do_reset();
    wr_ien(8'h97);
    irq_ack_i = 1'b1; tick(); irq_ack_i = 1'b0;
    pulse(5'h08);
    chk("R3 idle ack ignored", irq_req_o, 1);
    chk("R3 tmr1 vec", irq_vec_o, 8'h14);
    irq_ack_i = 1'b1; tick(); irq_ack_i = 1'b0;
    chk("R3 ack drops req", irq_req_o, 0);
    chk("R3 ack keeps vec", irq_vec_o, 8'h14);
    pulse(5'h01);
    chk("R3 inhibited after ack", irq_req_o, 0);
    cmd_en_i = 1'b1; tick(); cmd_en_i = 1'b0;
    chk("R3 flag kept, re-arm", irq_req_o, 1);
    chk("R3 re-arm vec", irq_vec_o, 8'h04);

    // R9 / R10 / R11 hold sequence
    do_reset();
    irq_ret_i = 1'b1; tick(); irq_ret_i = 1'b0;
    chk("R11 ret without wake", hold_o, 0);
    hold_req_i = 1'b1; tick(); hold_req_i = 1'b0;
    chk("R9 hold entered", hold_o, 1);
    wr_ien(8'h04);
    pulse(5'h04);
    chk("R10 req in hold", irq_req_o, 1);
    chk("R10 hold not yet released", hold_o, 1);
    tick();
    chk("R10 hold released", hold_o, 0);
    chk("R8 port vec", irq_vec_o, 8'h0C);
    irq_ack_i = 1'b1; tick(); irq_ack_i = 1'b0;
    chk("R3 ack in service", irq_req_o, 0);
    irq_ret_i = 1'b1; tick(); irq_ret_i = 1'b0;
    chk("R11 hold re-entered", hold_o, 1);
    tick();
    chk("R11 stays held", hold_o, 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule